// File: doc/BRIEF.md
# Completion Tracking and Checking Scoreboard

This block keeps a table of outstanding non-posted requests. The table is indexed by the low bits of the request tag. When a request header leaves on the egress channel, the block writes an entry for it. The entry holds the requester ID, the full tag, the request kind and the length. It also holds the completion byte count and lower address that the request should produce, which the block works out from the byte enables and the low address byte.

When a completion header arrives on the ingress channel, the block looks up the entry for its tag. It runs the completion through a fixed-priority chain of checks against the stored request. One cycle later it reports a one-hot error vector and a discard flag. The entry is retired when the completion passes every check, and also when an unsuccessful completion is found while unsuccessful-completion checking is enabled. Five disable inputs switch off individual checks, for diagnostics.

Top module: `cpl_sb_top`

## Requirements
- R1: An accepted request records an entry at index `req_tag[IDX_W-1:0]`. `req_kind` uses 0 memory read, 1 memory write, 2 IO read, 3 IO write, 4 config read and 5 config write. A later completion that matches the entry and passes every check returns `res_err` = 0 with `res_discard` = 0, and it retires the entry.
- R2: The unexpected-completion error, `res_err` = 6'h08 (bit 3), has the highest priority. It is raised when the entry is invalid, when the requester ID differs, when the full 8-bit tag differs, or when `cpl_locked` is set. The entry is not retired.
- R3: The malformed error, `res_err` = 6'h04 (bit 2), is raised for any of these: a completion with data whose status is neither 0 (successful) nor 2 (config retry); status 2 answering a request that is not a config request; a completion with data answering a memory, IO or config write; a status-0 completion without data answering a read.
- R4: The malformed error (bit 2) is also raised by any of these later checks: nonzero `cpl_attr`; nonzero `cpl_tc`; a completion with data whose length differs from the request length; a byte count other than 4 for IO or config requests; a byte count other than the expected value for memory reads; a lower address other than 0 for IO or config requests; a lower address other than the expected value for memory reads.
- R5: `chk_dis_crs`, `chk_dis_attr`, `chk_dis_tc`, `chk_dis_bcnt` and `chk_dis_laddr` each switch off one check. They cover, in that order, the retry-on-non-config check, the Attr check, the TC check, the byte-count check and the lower-address check.
- R6: Status 2 answering a config request gives `res_err` = 6'h02 (bit 1) with discard set. The entry is kept.
- R7: With `chk_ucmp_en` high, a nonzero status answering a read gives 6'h10 (bit 4), and answering a write gives 6'h20 (bit 5). In both cases the entry is retired and `res_discard` stays 0.
- R8: With `chk_ucmp_en` low, status 4 (abort), status 1 or a reserved status (3, 5, 6, 7) answering a read gives 6'h10. The same statuses answering an IO or config write give 6'h20. The entry is kept and discard stays 0.
- R9: Expected values are derived as follows:
  - A zero first byte enable gives a byte count of 1 and lower address bits [1:0] of 0.
  - A single-DW request (last byte enable zero) gives a byte count of 1 for one enabled byte, 2 for 4'b0011, 4'b0110 or 4'b1100, 4 when bits 0 and 3 are both set, and 3 otherwise.
  - A multi-DW request gives a byte count of len*4, minus the trailing zeros of the first byte enable, minus the leading zeros of the last byte enable.
  - When the first byte enable is nonzero, lower address bits [1:0] equal its trailing-zero count.
  - Bits [6:2] come from `req_addr_b15` when `req_hdr4dw` is set and from `req_addr_b11` otherwise.
- R10: `res_valid`, `res_err` and `res_discard` appear in the cycle after the completion is accepted and last one cycle. `dup_warn` pulses in the cycle after a request lands on an entry that was already valid.
- R11: When a request and a completion hit the same entry in the same cycle, the completion is checked against the old contents, and the new request is the one that stays recorded.
- R12: Only the highest-priority matching check is reported, so `res_err` has at most one bit set, and bit 0 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Egress request header valid |
| req_ready | output | 1 | Always high |
| req_kind | input | 3 | Request kind code |
| req_rid | input | 16 | Requester ID |
| req_tag | input | 8 | Request tag |
| req_len | input | 10 | Length in DW |
| req_first_be | input | 4 | First DW byte enables |
| req_last_be | input | 4 | Last DW byte enables |
| req_hdr4dw | input | 1 | Header is the 4-DW format |
| req_addr_b11 | input | 8 | Header byte 11 (low address byte for the 3-DW format) |
| req_addr_b15 | input | 8 | Header byte 15 (low address byte for the 4-DW format) |
| cpl_valid | input | 1 | Ingress completion header valid |
| cpl_ready | output | 1 | Always high |
| cpl_rid | input | 16 | Requester ID in the completion |
| cpl_tag | input | 8 | Tag in the completion |
| cpl_has_data | input | 1 | Completion carries data |
| cpl_locked | input | 1 | Completion is a locked type |
| cpl_status | input | 3 | Completion status |
| cpl_attr | input | 2 | Attr field |
| cpl_tc | input | 3 | Traffic class |
| cpl_len | input | 10 | Length in DW |
| cpl_bcnt | input | 12 | Byte count |
| cpl_laddr | input | 7 | Lower address |
| chk_dis_crs | input | 1 | Disable the retry-on-non-config check |
| chk_dis_attr | input | 1 | Disable the Attr check |
| chk_dis_tc | input | 1 | Disable the TC check |
| chk_dis_bcnt | input | 1 | Disable the byte-count check |
| chk_dis_laddr | input | 1 | Disable the lower-address check |
| chk_ucmp_en | input | 1 | Enable unsuccessful-completion checking |
| res_valid | output | 1 | Result valid |
| res_err | output | 6 | One-hot error vector |
| res_discard | output | 1 | Discard the completion |
| dup_warn | output | 1 | A request overwrote a valid entry |

## Verification
Each completion is driven on a falling edge and accepted at the next rising edge. Its error vector and discard flag are due right after that edge, so the bench samples them at the following falling edge. One cycle later it checks that `res_valid` has dropped again. `dup_warn` follows the same one-register latency from the request edge, and the bench samples it at the same point as a completion result. Whether an entry was retired or kept is never read from the design: the bench sends a follow-up completion and checks for an unexpected error or a clean result.

// File: rtl/cpl_sb_pkg.sv
package cpl_sb_pkg;
    localparam int TAG_W = 8;
    localparam int RID_W = 16;
    localparam int LEN_W = 10;
    localparam int BC_W  = 12;
    localparam int LA_W  = 7;
    localparam int ERR_W = 6;

    localparam int ERR_RETRY = 1;
    localparam int ERR_MALF  = 2;
    localparam int ERR_UNEXP = 3;
    localparam int ERR_RDBAD = 4;
    localparam int ERR_WRBAD = 5;

    localparam logic [2:0] ST_SC  = 3'd0;
    localparam logic [2:0] ST_UR  = 3'd1;
    localparam logic [2:0] ST_CRS = 3'd2;
    localparam logic [2:0] ST_CA  = 3'd4;

    typedef enum logic [2:0] {
        RK_MEM_RD = 3'd0, RK_MEM_WR = 3'd1, RK_IO_RD = 3'd2,
        RK_IO_WR  = 3'd3, RK_CFG_RD = 3'd4, RK_CFG_WR = 3'd5
    } req_kind_e;

    typedef struct packed {
        logic [RID_W-1:0] rid;
        logic [TAG_W-1:0] tag;
        req_kind_e        kind;
        logic [LEN_W-1:0] len;
        logic [BC_W-1:0]  bc;
        logic [LA_W-1:0]  la;
    } sb_rec_t;

    typedef struct packed {
        logic [RID_W-1:0] rid;
        logic [TAG_W-1:0] tag;
        logic             has_data;
        logic             locked;
        logic [2:0]       status;
        logic [1:0]       attr;
        logic [2:0]       tc;
        logic [LEN_W-1:0] len;
        logic [BC_W-1:0]  bc;
        logic [LA_W-1:0]  la;
    } cpl_hdr_t;

    typedef struct packed {
        logic dis_crs;
        logic dis_attr;
        logic dis_tc;
        logic dis_bcnt;
        logic dis_laddr;
        logic ucmp_en;
    } chk_ctl_t;

    function automatic logic kind_is_read(req_kind_e k);
        return k == RK_MEM_RD || k == RK_IO_RD || k == RK_CFG_RD;
    endfunction

    function automatic logic kind_is_write(req_kind_e k);
        return k == RK_MEM_WR || k == RK_IO_WR || k == RK_CFG_WR;
    endfunction

    function automatic logic kind_is_cfg(req_kind_e k);
        return k == RK_CFG_RD || k == RK_CFG_WR;
    endfunction

    function automatic logic kind_is_iocfg(req_kind_e k);
        return k == RK_IO_RD || k == RK_IO_WR || k == RK_CFG_RD || k == RK_CFG_WR;
    endfunction

    // zeros below the lowest set bit (4 for an empty mask)
    function automatic logic [2:0] low_zeros(logic [3:0] be);
        logic [2:0] n;
        n = 3'd4;
        for (int i = 3; i >= 0; i--) if (be[i]) n = 3'(i);
        return n;
    endfunction

    // zeros above the highest set bit (4 for an empty mask)
    function automatic logic [2:0] high_zeros(logic [3:0] be);
        logic [2:0] n;
        n = 3'd4;
        for (int i = 0; i < 4; i++) if (be[i]) n = 3'(3 - i);
        return n;
    endfunction
endpackage

// File: rtl/cpl_sb_expect.sv
module cpl_sb_expect
    import cpl_sb_pkg::*;
(
    input  logic [LEN_W-1:0] len,
    input  logic [3:0]       first_be,
    input  logic [3:0]       last_be,
    input  logic             hdr4dw,
    input  logic [7:0]       addr_b11,
    input  logic [7:0]       addr_b15,
    output logic [BC_W-1:0]  exp_bc,
    output logic [LA_W-1:0]  exp_la
);
    logic [7:0] addr_byte;
    logic [2:0] fz;
    logic [2:0] lz;

    assign addr_byte = hdr4dw ? addr_b15 : addr_b11;
    assign fz        = low_zeros(first_be);
    assign lz        = high_zeros(last_be);

    always_comb begin
        exp_la[6:2] = addr_byte[6:2];
        exp_la[1:0] = (first_be == 4'd0) ? 2'd0 : fz[1:0];
        if (first_be == 4'd0) begin
            exp_bc = BC_W'(1);
        end else if (last_be == 4'd0) begin
            unique case (first_be)
                4'b0001, 4'b0010, 4'b0100, 4'b1000: exp_bc = BC_W'(1);
                4'b0011, 4'b0110, 4'b1100:          exp_bc = BC_W'(2);
                default: exp_bc = (first_be[0] && first_be[3]) ? BC_W'(4) : BC_W'(3);
            endcase
        end else begin
            exp_bc = {len, 2'b00} - BC_W'(fz) - BC_W'(lz);
        end
    end
endmodule

// File: rtl/cpl_sb_table.sv
module cpl_sb_table
    import cpl_sb_pkg::*;
#(
    parameter  int IDX_W = 5,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  sb_rec_t          wr_rec,
    output logic             wr_was_vld,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_vld,
    output sb_rec_t          rd_rec,
    input  logic             ret_en,
    input  logic [IDX_W-1:0] ret_idx
);
    logic [DEPTH-1:0] vld_vec;
    sb_rec_t          rec_arr [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic    v_q;
        sb_rec_t r_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                v_q <= 1'b1;
            end else if (ret_en && ret_idx == IDX_W'(g)) begin
                v_q <= 1'b0;
            end
            if (wr_en && wr_idx == IDX_W'(g)) r_q <= wr_rec;
        end
        assign vld_vec[g] = v_q;
        assign rec_arr[g] = r_q;
    end

    assign rd_vld     = vld_vec[rd_idx];
    assign rd_rec     = rec_arr[rd_idx];
    assign wr_was_vld = vld_vec[wr_idx];

    p_write_sets_valid_r1: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> vld_vec[$past(wr_idx)]);
    p_retire_clears_r7: assert property (@(posedge clk) disable iff (rst)
        ret_en && !(wr_en && wr_idx == ret_idx) |=> !vld_vec[$past(ret_idx)]);
    p_write_beats_retire_r11: assert property (@(posedge clk) disable iff (rst)
        wr_en && ret_en && wr_idx == ret_idx |=> rec_arr[$past(wr_idx)] == $past(wr_rec));
endmodule

// File: rtl/cpl_sb_classify.sv
module cpl_sb_classify
    import cpl_sb_pkg::*;
(
    input  logic             ent_vld,
    input  sb_rec_t          ent,
    input  cpl_hdr_t         cpl,
    input  chk_ctl_t         ctl,
    output logic [ERR_W-1:0] err,
    output logic             retire
);
    logic rd, wr, cfg, iocfg, iocfg_wr, mrd, ur_rsv;
    logic [2:0] st;

    assign st       = cpl.status;
    assign rd       = kind_is_read(ent.kind);
    assign wr       = kind_is_write(ent.kind);
    assign cfg      = kind_is_cfg(ent.kind);
    assign iocfg    = kind_is_iocfg(ent.kind);
    assign iocfg_wr = ent.kind == RK_IO_WR || ent.kind == RK_CFG_WR;
    assign mrd      = ent.kind == RK_MEM_RD;
    assign ur_rsv   = st == ST_UR || st == 3'd3 || st >= 3'd5;

    always_comb begin
        err    = '0;
        retire = 1'b0;
        if (!ent_vld || ent.rid != cpl.rid || ent.tag != cpl.tag || cpl.locked)
            err[ERR_UNEXP] = 1'b1;
        else if (cpl.has_data && st != ST_SC && st != ST_CRS)
            err[ERR_MALF] = 1'b1;
        else if (!ctl.dis_crs && st == ST_CRS && !cfg)
            err[ERR_MALF] = 1'b1;
        else if (cpl.has_data && wr)
            err[ERR_MALF] = 1'b1;
        else if (!cpl.has_data && st == ST_SC && rd)
            err[ERR_MALF] = 1'b1;
        else if ((cpl.attr != 2'd0 && !ctl.dis_attr) || (cpl.tc != 3'd0 && !ctl.dis_tc))
            err[ERR_MALF] = 1'b1;
        else if (cpl.has_data && cpl.len != ent.len)
            err[ERR_MALF] = 1'b1;
        else if (!ctl.dis_bcnt && ((iocfg && cpl.bc != BC_W'(4)) || (mrd && cpl.bc != ent.bc)))
            err[ERR_MALF] = 1'b1;
        else if (!ctl.dis_laddr && ((iocfg && cpl.la != '0) || (mrd && cpl.la != ent.la)))
            err[ERR_MALF] = 1'b1;
        else if (st == ST_CRS && cfg)
            err[ERR_RETRY] = 1'b1;
        else if (ctl.ucmp_en && st != ST_SC && rd) begin
            err[ERR_RDBAD] = 1'b1;
            retire = 1'b1;
        end else if (ctl.ucmp_en && st != ST_SC && wr) begin
            err[ERR_WRBAD] = 1'b1;
            retire = 1'b1;
        end else if (st == ST_CA && rd)
            err[ERR_RDBAD] = 1'b1;
        else if (st == ST_CA && iocfg_wr)
            err[ERR_WRBAD] = 1'b1;
        else if (ur_rsv && iocfg_wr)
            err[ERR_WRBAD] = 1'b1;
        else if (ur_rsv && rd)
            err[ERR_RDBAD] = 1'b1;
        else
            retire = 1'b1;
    end
endmodule

// File: rtl/cpl_sb_top.sv
module cpl_sb_top
    import cpl_sb_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_kind,
    input  logic [15:0]      req_rid,
    input  logic [7:0]       req_tag,
    input  logic [9:0]       req_len,
    input  logic [3:0]       req_first_be,
    input  logic [3:0]       req_last_be,
    input  logic             req_hdr4dw,
    input  logic [7:0]       req_addr_b11,
    input  logic [7:0]       req_addr_b15,
    input  logic             cpl_valid,
    output logic             cpl_ready,
    input  logic [15:0]      cpl_rid,
    input  logic [7:0]       cpl_tag,
    input  logic             cpl_has_data,
    input  logic             cpl_locked,
    input  logic [2:0]       cpl_status,
    input  logic [1:0]       cpl_attr,
    input  logic [2:0]       cpl_tc,
    input  logic [9:0]       cpl_len,
    input  logic [11:0]      cpl_bcnt,
    input  logic [6:0]       cpl_laddr,
    input  logic             chk_dis_crs,
    input  logic             chk_dis_attr,
    input  logic             chk_dis_tc,
    input  logic             chk_dis_bcnt,
    input  logic             chk_dis_laddr,
    input  logic             chk_ucmp_en,
    output logic             res_valid,
    output logic [5:0]       res_err,
    output logic             res_discard,
    output logic             dup_warn
);
    logic [BC_W-1:0]  exp_bc;
    logic [LA_W-1:0]  exp_la;
    sb_rec_t          new_rec, ent;
    cpl_hdr_t         chdr;
    chk_ctl_t         ctl;
    logic             ent_vld, was_vld, cls_retire;
    logic [ERR_W-1:0] cls_err;

    assign req_ready = 1'b1;
    assign cpl_ready = 1'b1;

    cpl_sb_expect u_expect (
        .len(req_len), .first_be(req_first_be), .last_be(req_last_be),
        .hdr4dw(req_hdr4dw), .addr_b11(req_addr_b11), .addr_b15(req_addr_b15),
        .exp_bc(exp_bc), .exp_la(exp_la)
    );

    assign new_rec = '{rid: req_rid, tag: req_tag, kind: req_kind_e'(req_kind),
                       len: req_len, bc: exp_bc, la: exp_la};
    assign chdr = '{rid: cpl_rid, tag: cpl_tag, has_data: cpl_has_data, locked: cpl_locked,
                    status: cpl_status, attr: cpl_attr, tc: cpl_tc, len: cpl_len,
                    bc: cpl_bcnt, la: cpl_laddr};
    assign ctl = '{dis_crs: chk_dis_crs, dis_attr: chk_dis_attr, dis_tc: chk_dis_tc,
                   dis_bcnt: chk_dis_bcnt, dis_laddr: chk_dis_laddr, ucmp_en: chk_ucmp_en};

    cpl_sb_table #(.IDX_W(IDX_W)) u_table (
        .clk(clk), .rst(rst),
        .wr_en(req_valid), .wr_idx(req_tag[IDX_W-1:0]), .wr_rec(new_rec), .wr_was_vld(was_vld),
        .rd_idx(cpl_tag[IDX_W-1:0]), .rd_vld(ent_vld), .rd_rec(ent),
        .ret_en(cpl_valid && cls_retire), .ret_idx(cpl_tag[IDX_W-1:0])
    );

    cpl_sb_classify u_classify (
        .ent_vld(ent_vld), .ent(ent), .cpl(chdr), .ctl(ctl),
        .err(cls_err), .retire(cls_retire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_err     <= '0;
            res_discard <= 1'b0;
            dup_warn    <= 1'b0;
        end else begin
            res_valid   <= cpl_valid;
            res_err     <= cpl_valid ? cls_err : '0;
            res_discard <= cpl_valid && (cls_err[ERR_RETRY] || cls_err[ERR_MALF] || cls_err[ERR_UNEXP]);
            dup_warn    <= req_valid && was_vld;
        end
    end

    p_one_class_r12: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $onehot0(res_err) && !res_err[0]);
    p_fwd_on_fail_r7: assert property (@(posedge clk) disable iff (rst)
        res_valid && (res_err[ERR_RDBAD] || res_err[ERR_WRBAD]) |-> !res_discard);
    p_result_timing_r10: assert property (@(posedge clk) disable iff (rst)
        res_discard |-> res_valid && $past(cpl_valid));
    p_dup_after_req_r10: assert property (@(posedge clk) disable iff (rst)
        dup_warn |-> $past(req_valid));
    p_bc_bound_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_first_be != 4'd0 && req_len != '0 |-> exp_bc <= {req_len, 2'b00});
    initial begin
        p_idx_fits_r1: assert (IDX_W >= 1 && IDX_W <= TAG_W);
    end
endmodule

// File: tb/cpl_sb_top_tb_top.sv
module cpl_sb_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic req_valid = 0, req_ready, req_hdr4dw = 0;
    logic [2:0] req_kind = 0;
    logic [15:0] req_rid = 0;
    logic [7:0] req_tag = 0, req_addr_b11 = 0, req_addr_b15 = 0;
    logic [9:0] req_len = 0;
    logic [3:0] req_first_be = 0, req_last_be = 0;
    logic cpl_valid = 0, cpl_ready, cpl_has_data = 0, cpl_locked = 0;
    logic [15:0] cpl_rid = 0;
    logic [7:0] cpl_tag = 0;
    logic [2:0] cpl_status = 0, cpl_tc = 0;
    logic [1:0] cpl_attr = 0;
    logic [9:0] cpl_len = 0;
    logic [11:0] cpl_bcnt = 0;
    logic [6:0] cpl_laddr = 0;
    logic dis_crs = 0, dis_attr = 0, dis_tc = 0, dis_bcnt = 0, dis_laddr = 0, ucmp_en = 0;
    logic res_valid, res_discard, dup_warn;
    logic [5:0] res_err;

    int n_chk = 0, n_bad = 0;
    logic [5:0] got_err;
    logic got_disc, got_dup;

    localparam logic [2:0] MRD = 0, MWR = 1, IORD = 2, IOWR = 3, CFGRD = 4, CFGWR = 5;
    localparam logic [15:0] RID = 16'hA001;

    cpl_sb_top dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind), .req_rid(req_rid),
        .req_tag(req_tag), .req_len(req_len), .req_first_be(req_first_be),
        .req_last_be(req_last_be), .req_hdr4dw(req_hdr4dw), .req_addr_b11(req_addr_b11),
        .req_addr_b15(req_addr_b15),
        .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_rid(cpl_rid), .cpl_tag(cpl_tag),
        .cpl_has_data(cpl_has_data), .cpl_locked(cpl_locked), .cpl_status(cpl_status),
        .cpl_attr(cpl_attr), .cpl_tc(cpl_tc), .cpl_len(cpl_len), .cpl_bcnt(cpl_bcnt),
        .cpl_laddr(cpl_laddr),
        .chk_dis_crs(dis_crs), .chk_dis_attr(dis_attr), .chk_dis_tc(dis_tc),
        .chk_dis_bcnt(dis_bcnt), .chk_dis_laddr(dis_laddr), .chk_ucmp_en(ucmp_en),
        .res_valid(res_valid), .res_err(res_err), .res_discard(res_discard), .dup_warn(dup_warn)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_req(logic [2:0] k, logic [7:0] t, logic [15:0] r, logic [9:0] l,
                           logic [3:0] fb, logic [3:0] lb, logic f4, logic [7:0] b11, logic [7:0] b15);
        req_valid = 1; req_kind = k; req_tag = t; req_rid = r; req_len = l;
        req_first_be = fb; req_last_be = lb; req_hdr4dw = f4; req_addr_b11 = b11; req_addr_b15 = b15;
    endtask

    task automatic set_cpl(logic [7:0] t, logic [15:0] r, logic d, logic lk, logic [2:0] st,
                           logic [1:0] at, logic [2:0] tc, logic [9:0] l, logic [11:0] bc, logic [6:0] la);
        cpl_valid = 1; cpl_tag = t; cpl_rid = r; cpl_has_data = d; cpl_locked = lk;
        cpl_status = st; cpl_attr = at; cpl_tc = tc; cpl_len = l; cpl_bcnt = bc; cpl_laddr = la;
    endtask

    // one cycle: inputs applied on falling edge, results read at the next falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; cpl_valid = 0;
        got_err = res_err; got_disc = res_discard; got_dup = dup_warn;
    endtask

    task automatic do_req(logic [2:0] k, logic [7:0] t, logic [3:0] fb, logic [3:0] lb,
                          logic [9:0] l, logic f4, logic [7:0] b11, logic [7:0] b15);
        @(negedge clk);
        set_req(k, t, RID, l, fb, lb, f4, b11, b15);
        step();
    endtask

    task automatic do_cpl(logic [7:0] t, logic [15:0] r, logic d, logic lk, logic [2:0] st,
                          logic [1:0] at, logic [2:0] tc, logic [9:0] l, logic [11:0] bc, logic [6:0] la);
        @(negedge clk);
        set_cpl(t, r, d, lk, st, at, tc, l, bc, la);
        step();
    endtask

    // good data completion for a given tag
    task automatic good(logic [7:0] t, logic [9:0] l, logic [11:0] bc, logic [6:0] la);
        do_cpl(t, RID, 1, 0, 0, 0, 0, l, bc, la);
    endtask

    task automatic t_reset();
        check("R10 reset res_valid", res_valid, 0);
        check("R10 reset discard", res_discard, 0);
        check("R10 reset dup_warn", dup_warn, 0);
        good(8'd0, 1, 4, 0);
        check("R2 empty table unexpected", got_err, 6'h08);
        check("R2 unexpected discard", got_disc, 1);
    endtask

    task automatic t_record_retire();
        do_req(MRD, 8'd1, 4'b1100, 4'b0011, 4, 0, 8'h44, 8'h00);
        check("R10 no dup on fresh entry", got_dup, 0);
        good(8'd1, 4, 12, 7'h46);
        check("R1 R9 multi-DW good completion", got_err, 0);
        check("R1 good completion kept", got_disc, 0);
        @(negedge clk);
        check("R10 result lasts one cycle", res_valid, 0);
        good(8'd1, 4, 12, 7'h46);
        check("R1 entry retired", got_err, 6'h08);
    endtask

    task automatic t_unexpected();
        do_req(MRD, 8'd2, 4'b1111, 4'b0000, 1, 0, 8'h10, 8'h00);
        do_cpl(8'd2, 16'hBEEF, 1, 0, 0, 0, 0, 1, 4, 7'h10);
        check("R2 requester mismatch", got_err, 6'h08);
        do_cpl(8'd34, RID, 1, 0, 0, 0, 0, 1, 4, 7'h10);
        check("R2 full tag mismatch", got_err, 6'h08);
        do_cpl(8'd2, RID, 1, 1, 1, 1, 1, 1, 4, 7'h10);
        check("R2 R12 locked outranks others", got_err, 6'h08);
        good(8'd2, 1, 4, 7'h10);
        check("R2 entry survived mismatches", got_err, 0);
    endtask

    task automatic t_malformed();
        do_req(MRD, 8'd3, 4'b1111, 4'b0000, 1, 0, 8'h10, 8'h00);
        do_cpl(8'd3, RID, 1, 0, 1, 0, 0, 1, 4, 7'h10);
        check("R3 data with bad status", got_err, 6'h04);
        do_cpl(8'd3, RID, 0, 0, 2, 1, 0, 1, 4, 7'h10);
        check("R3 R12 retry on mem read", got_err, 6'h04);
        check("R3 malformed discard", got_disc, 1);
        do_cpl(8'd3, RID, 1, 0, 0, 1, 0, 1, 4, 7'h10);
        check("R4 attr nonzero", got_err, 6'h04);
        do_cpl(8'd3, RID, 1, 0, 0, 0, 2, 1, 4, 7'h10);
        check("R4 tc nonzero", got_err, 6'h04);
        do_cpl(8'd3, RID, 1, 0, 0, 0, 0, 2, 4, 7'h10);
        check("R4 length mismatch", got_err, 6'h04);
        do_cpl(8'd3, RID, 1, 0, 0, 0, 0, 1, 3, 7'h10);
        check("R4 mem byte count mismatch", got_err, 6'h04);
        do_cpl(8'd3, RID, 1, 0, 0, 0, 0, 1, 4, 7'h14);
        check("R4 mem lower address mismatch", got_err, 6'h04);
        do_req(IOWR, 8'd4, 4'b1111, 4'b0000, 1, 0, 0, 0);
        do_cpl(8'd4, RID, 1, 0, 0, 0, 0, 1, 4, 0);
        check("R3 data on write", got_err, 6'h04);
        do_req(IORD, 8'd5, 4'b1111, 4'b0000, 1, 0, 0, 0);
        do_cpl(8'd5, RID, 0, 0, 0, 0, 0, 1, 4, 0);
        check("R3 no data on successful read", got_err, 6'h04);
        do_cpl(8'd5, RID, 1, 0, 0, 0, 0, 1, 8, 0);
        check("R4 io byte count not 4", got_err, 6'h04);
        do_cpl(8'd5, RID, 1, 0, 0, 0, 0, 1, 4, 7'h04);
        check("R4 io lower address not 0", got_err, 6'h04);
    endtask

    task automatic t_disables();
        do_req(MRD, 8'd6, 4'b1111, 4'b0000, 1, 0, 8'h10, 0);
        dis_attr = 1;
        do_cpl(8'd6, RID, 1, 0, 0, 1, 0, 1, 4, 7'h10);
        check("R5 attr check off", got_err, 0);
        dis_attr = 0; dis_tc = 1;
        do_req(MRD, 8'd6, 4'b1111, 4'b0000, 1, 0, 8'h10, 0);
        do_cpl(8'd6, RID, 1, 0, 0, 0, 5, 1, 4, 7'h10);
        check("R5 tc check off", got_err, 0);
        dis_tc = 0; dis_bcnt = 1;
        do_req(MRD, 8'd6, 4'b1111, 4'b0000, 1, 0, 8'h10, 0);
        do_cpl(8'd6, RID, 1, 0, 0, 0, 0, 1, 9, 7'h10);
        check("R5 byte count check off", got_err, 0);
        dis_bcnt = 0; dis_laddr = 1;
        do_req(MRD, 8'd6, 4'b1111, 4'b0000, 1, 0, 8'h10, 0);
        do_cpl(8'd6, RID, 1, 0, 0, 0, 0, 1, 4, 7'h33);
        check("R5 lower address check off", got_err, 0);
        dis_laddr = 0; dis_crs = 1;
        do_req(MRD, 8'd6, 4'b1111, 4'b0000, 1, 0, 8'h10, 0);
        do_cpl(8'd6, RID, 1, 0, 2, 0, 0, 1, 4, 7'h10);
        check("R5 retry-on-non-config check off", got_err, 0);
        dis_crs = 0;
    endtask

    task automatic t_retry_and_fail();
        do_req(CFGRD, 8'd7, 4'b1111, 4'b0000, 1, 0, 0, 0);
        do_cpl(8'd7, RID, 1, 0, 2, 0, 0, 1, 4, 0);
        check("R6 config retry", got_err, 6'h02);
        check("R6 retry discard", got_disc, 1);
        good(8'd7, 1, 4, 0);
        check("R6 entry kept after retry", got_err, 0);
        ucmp_en = 1;
        do_req(MRD, 8'd8, 4'b1111, 4'b0000, 1, 0, 8'h10, 0);
        do_cpl(8'd8, RID, 0, 0, 1, 0, 0, 1, 4, 7'h10);
        check("R7 unsuccessful read", got_err, 6'h10);
        check("R7 read failure forwarded", got_disc, 0);
        good(8'd8, 1, 4, 7'h10);
        check("R7 read entry retired", got_err, 6'h08);
        do_req(IOWR, 8'd9, 4'b1111, 4'b0000, 1, 0, 0, 0);
        do_cpl(8'd9, RID, 0, 0, 4, 0, 0, 1, 4, 0);
        check("R7 unsuccessful write", got_err, 6'h20);
        do_cpl(8'd9, RID, 0, 0, 0, 0, 0, 1, 4, 0);
        check("R7 write entry retired", got_err, 6'h08);
        ucmp_en = 0;
        do_req(CFGWR, 8'd10, 4'b1111, 4'b0000, 1, 0, 0, 0);
        do_cpl(8'd10, RID, 0, 0, 4, 0, 0, 1, 4, 0);
        check("R8 abort on config write", got_err, 6'h20);
        do_cpl(8'd10, RID, 0, 0, 0, 0, 0, 1, 4, 0);
        check("R8 entry kept after abort", got_err, 0);
        do_req(MRD, 8'd11, 4'b1111, 4'b0000, 1, 0, 8'h10, 0);
        do_cpl(8'd11, RID, 0, 0, 7, 0, 0, 1, 4, 7'h10);
        check("R8 reserved status on read", got_err, 6'h10);
        check("R8 no discard", got_disc, 0);
        do_req(IOWR, 8'd12, 4'b1111, 4'b0000, 1, 0, 0, 0);
        do_cpl(8'd12, RID, 0, 0, 1, 0, 0, 1, 4, 0);
        check("R8 unsupported status on io write", got_err, 6'h20);
    endtask

    task automatic t_expect();
        do_req(MRD, 8'd13, 4'b0110, 4'b0000, 1, 0, 8'h20, 0);
        good(8'd13, 1, 2, 7'h21);
        check("R9 two-byte single DW", got_err, 0);
        do_req(MRD, 8'd13, 4'b1001, 4'b0000, 1, 0, 8'h20, 0);
        good(8'd13, 1, 4, 7'h20);
        check("R9 ends-set single DW", got_err, 0);
        do_req(MRD, 8'd13, 4'b0111, 4'b0000, 1, 0, 8'h20, 0);
        good(8'd13, 1, 3, 7'h20);
        check("R9 three-byte single DW", got_err, 0);
        do_req(MRD, 8'd13, 4'b0000, 4'b0000, 1, 0, 8'h23, 0);
        good(8'd13, 1, 1, 7'h23);
        check("R9 zero enables low bits", got_err, 6'h04);
        good(8'd13, 1, 1, 7'h20);
        check("R9 zero enables", got_err, 0);
        do_req(MRD, 8'd14, 4'b1000, 4'b0111, 2, 1, 8'h00, 8'h5C);
        good(8'd14, 2, 4, 7'h5F);
        check("R9 4-DW header address byte", got_err, 0);
    endtask

    task automatic t_dup_and_collision();
        do_req(MRD, 8'd15, 4'b1111, 4'b0000, 1, 0, 8'h10, 0);
        @(negedge clk);
        set_req(MRD, 8'd15, 16'h00B2, 1, 4'b1111, 4'b0000, 0, 8'h10, 0);
        set_cpl(8'd15, RID, 1, 0, 0, 0, 0, 1, 4, 7'h10);
        step();
        check("R11 old entry checked", got_err, 0);
        check("R10 overwrite warning", got_dup, 1);
        do_cpl(8'd15, 16'h00B2, 1, 0, 0, 0, 0, 1, 4, 7'h10);
        check("R11 new request kept", got_err, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_record_retire();
        t_unexpected();
        t_malformed();
        t_disables();
        t_retry_and_fail();
        t_expect();
        t_dup_and_collision();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule